// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Less-Than

This block is a purely combinational 32-bit integer unit made of one-bit slices chained through their carries. Each slice holds a full adder, an AND gate, an OR gate and a four-way result multiplexer. One control bit inverts the b operand and also supplies the carry into bit 0. Raising that bit turns the adder into a subtractor, because a − b is computed as a + ~b + 1.

The top slice alone detects signed overflow and produces the comparison bit. That bit is the sign of the difference, corrected by the overflow flag, and it is fed back as the bit-0 result of the set-on-less-than operation. A zero flag is raised when the 32-bit result is all zeros. The unit has no clock: outputs follow the inputs after the ripple delay.

Top module: `bitslice_alu`

## Requirements
- R1: With ctrl[1:0]=00 the result is a AND b when ctrl[2]=0, and a AND NOT b when ctrl[2]=1.
- R2: With ctrl[1:0]=01 the result is a OR b when ctrl[2]=0, and a OR NOT b when ctrl[2]=1.
- R3: With ctrl=0010 the result is (a+b) mod 2^32, and carry_out is bit 32 of the unsigned sum.
- R4: With ctrl=0110 the result is (a−b) mod 2^32, and carry_out is 1 exactly when a ≥ b as unsigned numbers.
- R5: overflow is 1 exactly when the adder's signed result falls outside the 32-bit two's-complement range. This means a+b when ctrl[2]=0 and a−b when ctrl[2]=1, whatever the ctrl[1:0] value.
- R6: With ctrl=0111 the result is 1 when a < b as signed numbers and 0 otherwise, with bits 31:1 zero. This holds even when a−b overflows.
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: ctrl[3] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| ctrl | input | 4 | Bit 3 is ignored. Bit 2 inverts b and sets the carry-in. Bits 1:0 select AND=00, OR=01, ADD=10, SLT=11 |
| result | output | 32 | Selected result |
| carry_out | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Signed overflow of the adder |
| zero | output | 1 | Result is all zeros |

## Verification
The bench targets the carry chain at its ends. All-ones plus one must ripple through every slice and yield a zero result with carry set. A broken link in the chain would leave high bits set or drop the carry.

Signed overflow is driven from both directions, for addition and for subtraction. A design that tested the raw operand signs without regard to the operation would flag 0x80000000 − 1 wrongly.

Set-on-less-than is checked on operand pairs whose difference overflows, such as 0x80000000 against 1 and 0x7fffffff against −1. A design that used the raw sign bit of the difference would return the inverted answer on these pairs.

A final group repeats the vectors with ctrl[3] set and with b inverted under the logic operations. This exposes a design that decodes the ignored bit, or that applies the inversion only to the adder.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   ctrl,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow,
  output logic         zero
);
  logic set_bit;
  logic unused_ctrl;
  assign unused_ctrl = ctrl[3];

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_slice
      logic cin, cout, bx, sum, less;
      assign bx = b[i] ^ ctrl[2];
      if (i == 0) begin : g_first
        assign cin  = ctrl[2];
        assign less = set_bit;
      end else begin : g_rest
        assign cin  = g_slice[i-1].cout;
        assign less = 1'b0;
      end
      assign sum  = a[i] ^ bx ^ cin;
      assign cout = (a[i] & bx) | (a[i] & cin) | (bx & cin);
      assign result[i] = (ctrl[1:0] == 2'b00) ? (a[i] & bx) :
                         (ctrl[1:0] == 2'b01) ? (a[i] | bx) :
                         (ctrl[1:0] == 2'b10) ? sum : less;
      if (i == W-1) begin : g_top
        assign overflow  = (ctrl[2] ? (a[i] ^ b[i]) : ~(a[i] ^ b[i])) & (sum ^ a[i]);
        assign set_bit   = sum ^ overflow;
        assign carry_out = cout;
      end
    end
  endgenerate

  assign zero = ~|result;
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   ctrl,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         overflow,
  input logic         zero
);
  logic [W:0]   add_ref, sub_ref;
  logic signed [W:0] sadd, ssub;
  always_comb begin
    add_ref = {1'b0, a} + {1'b0, b};
    sub_ref = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    sadd = $signed({a[W-1], a}) + $signed({b[W-1], b});
    ssub = $signed({a[W-1], a}) - $signed({b[W-1], b});
    if (!$isunknown({a, b, ctrl})) begin
      if (ctrl[2:0] == 3'b010) begin
        p_add_sum_r3: assert ({carry_out, result} == add_ref)
          else $error("R3 add mismatch");
        p_add_ovf_r5: assert (overflow == (sadd[W] != sadd[W-1]))
          else $error("R5 add overflow mismatch");
      end
      if (ctrl[2:0] == 3'b110) begin
        p_sub_diff_r4: assert ({carry_out, result} == sub_ref)
          else $error("R4 subtract mismatch");
        p_sub_ovf_r5: assert (overflow == (ssub[W] != ssub[W-1]))
          else $error("R5 subtract overflow mismatch");
        p_sub_zero_r7: assert (zero == (a == b))
          else $error("R7 zero mismatch");
      end
      if (ctrl[2:0] == 3'b111) begin
        p_slt_bit_r6: assert (result == {{(W-1){1'b0}}, ($signed(a) < $signed(b))})
          else $error("R6 set-less-than mismatch");
      end
      if (ctrl[2:0] == 3'b000) begin
        p_and_r1: assert (result == (a & b)) else $error("R1 and mismatch");
      end
    end
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) chk_i (.*);

// File: tb/bitslice_alu_tb_top.sv
module bitslice_alu_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a, b, result;
  logic [3:0]  ctrl;
  logic        carry_out, overflow, zero;
  int checks = 0;
  int errors = 0;

  bitslice_alu dut_i (.a(a), .b(b), .ctrl(ctrl), .result(result),
                      .carry_out(carry_out), .overflow(overflow), .zero(zero));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic [3:0] cv);
    @(posedge clk);
    a = av; b = bv; ctrl = cv;
    @(negedge clk);
  endtask

  task automatic expect_all(input string tag, input logic [31:0] r, input logic c,
                            input logic o, input logic z);
    check({tag, " result"}, result, r);
    check({tag, " carry"}, {31'b0, carry_out}, {31'b0, c});
    check({tag, " overflow R5"}, {31'b0, overflow}, {31'b0, o});
    check({tag, " zero R7"}, {31'b0, zero}, {31'b0, z});
  endtask

  task automatic t_idle();
    apply(32'h0, 32'h0, 4'b0000);
    check("R7 idle zero flag", {31'b0, zero}, 32'd1);
    check("R1 idle result", result, 32'h0);
  endtask

  task automatic t_logic();
    apply(32'hF0F0_1234, 32'hFF00_FF00, 4'b0000);
    check("R1 and", result, 32'hF000_1200);
    apply(32'hF0F0_1234, 32'hFF00_FF00, 4'b0100);
    check("R1 and-not", result, 32'h00F0_0034);
    apply(32'hF0F0_1234, 32'h0F00_0001, 4'b0001);
    check("R2 or", result, 32'hFFF0_1235);
    apply(32'h0000_0000, 32'hFFFF_FFFE, 4'b0101);
    check("R2 or-not", result, 32'h0000_0001);
    apply(32'h1234_0000, 32'h0000_5678, 4'b0000);
    check("R7 and gives zero", {31'b0, zero}, 32'd1);
  endtask

  task automatic t_add();
    apply(32'd100, 32'd23, 4'b0010);
    expect_all("R3 small add", 32'd123, 1'b0, 1'b0, 1'b0);
    apply(32'hFFFF_FFFF, 32'd1, 4'b0010);
    expect_all("R3 full ripple", 32'h0, 1'b1, 1'b0, 1'b1);
    apply(32'h7FFF_FFFF, 32'd1, 4'b0010);
    expect_all("R5 positive overflow", 32'h8000_0000, 1'b0, 1'b1, 1'b0);
    apply(32'h8000_0000, 32'h8000_0000, 4'b0010);
    expect_all("R5 negative overflow", 32'h0, 1'b1, 1'b1, 1'b1);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0000);
    check("R5 overflow under AND select", {31'b0, overflow}, 32'd1);
  endtask

  task automatic t_sub();
    apply(32'd5, 32'd5, 4'b0110);
    expect_all("R4 equal", 32'h0, 1'b1, 1'b0, 1'b1);
    apply(32'd3, 32'd5, 4'b0110);
    expect_all("R4 borrow", 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0);
    apply(32'h8000_0000, 32'd1, 4'b0110);
    expect_all("R5 sub overflow", 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110);
    expect_all("R5 sub overflow pos", 32'h8000_0000, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_slt();
    apply(32'hFFFF_FFFF, 32'd1, 4'b0111);
    check("R6 -1<1", result, 32'd1);
    apply(32'd5, 32'd3, 4'b0111);
    check("R6 5<3", result, 32'd0);
    apply(32'h8000_0000, 32'd1, 4'b0111);
    check("R6 min<1 overflowing", result, 32'd1);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    check("R6 max<-1 overflowing", result, 32'd0);
    apply(32'd9, 32'd9, 4'b0111);
    check("R6 equal", result, 32'd0);
    check("R7 slt zero", {31'b0, zero}, 32'd1);
  endtask

  task automatic t_sweep();
    logic [31:0] x = 32'h1357_9BDF;
    logic [31:0] y = 32'hACE0_2468;
    for (int k = 0; k < 24; k++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      y = {y[30:0], y[31] ^ y[21] ^ y[1] ^ y[0]} ^ x;
      apply(x, y, 4'b0010);
      check("R3 sweep", result, x + y);
      apply(x, y, 4'b0110);
      check("R4 sweep", result, x - y);
      apply(x, y, 4'b0111);
      check("R6 sweep", result, {31'b0, ($signed(x) < $signed(y))});
    end
  endtask

  task automatic t_ignored();
    apply(32'h8000_0000, 32'd1, 4'b1111);
    check("R8 slt with bit3", result, 32'd1);
    apply(32'hFFFF_FFFF, 32'd1, 4'b1010);
    expect_all("R8 add with bit3", 32'h0, 1'b1, 1'b0, 1'b1);
    apply(32'hF0F0_1234, 32'hFF00_FF00, 4'b1100);
    check("R8 and-not with bit3", result, 32'h00F0_0034);
  endtask

  initial begin
    a = '0; b = '0; ctrl = '0;
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_sweep();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule